// File: doc/BRIEF.md
# Command Completion and Extended Status Formatter

This block closes out every command of a two-drive floppy controller. When the command sequencer signals that a command has ended, the block does several things in one cycle. It raises done and merges the supplied error flags into a 12-bit error-status register. It clears and rebuilds the three drive-dependent status bits from the drive that is selected at that moment. It sets the control error bit when the outcome calls for it, stores the new error code and copies the status word into the data buffer register. An interrupt request follows done whenever interrupts are enabled.

It also runs two tasks that finish commands on their own. The first is a word-count guard for buffer fill and empty: it rejects a count whose byte size is larger than one sector at the requested density. The second is an extended-status sender. It captures an eight-byte snapshot of controller and drive state and streams it out as byte beats on a valid/ready DMA write port. Command decoding and media access belong to neighbouring blocks.

Top module: `cstat_unit`

## Requirements
- R1: After reset, done, csr_err, irq, xs_busy, dma_valid and fe_go are 0, and esr, dbr and ecode are 0.
- R2: A completion request (cmpl_req high for one cycle while no packet is in flight) sets done, stores cmpl_code in ecode and ORs cmpl_flags into esr, with effect from the next clock edge. The esr bit positions are: 0 CRC error, 2 init done, 3 power low, 4 density error, 5 drive double density, 6 deleted data, 7 drive ready, 8 unit selected, 10 word-count overflow, 11 nonexistent memory.
- R3: On every completion, esr bits 8, 7 and 5 are first cleared and then rebuilt. Bit 8 is drv_sel. Bit 7 is media[drv_sel]. Bit 5 is media[drv_sel] and dd[drv_sel].
- R4: On completion, csr_err is set if the new code is nonzero or if any of esr bits 11, 10, 4, 3 or 0 is set after the merge. Init done (bit 2) alone does not set it.
- R5: On completion, dbr takes the value {4'b0, esr} of the new status word.
- R6: irq is high exactly when done and ie are both high.
- R7: cmd_start clears done and csr_err. If cmd_rw is also high, it clears every esr bit except bit 2 and sets ecode to 0. Otherwise esr and ecode are left unchanged.
- R8: On fe_req, the count is checked against the sector size, which is 256 bytes when den_sel is 1 and 128 bytes when it is 0. If 2*wcount is larger than the sector size, the command completes with esr bit 10 and code octal 230 (8'h98). If it is not larger, fe_go pulses for one cycle and no completion occurs.
- R9: xs_start latches xs_addr and an 8-byte packet, which is sent as beats to xs_addr+0 .. xs_addr+7. The bytes, in beat order, are: ecode, wcount, trk0, trk1, req_trk, req_sec, flags, and the track of the selected drive. The flags byte holds drv_sel in bit 7, dd[1] in bit 6, media[drv_sel] in bit 5, dd[0] in bit 4 and den_sel in bit 0; its other bits are 0.
- R10: While dma_valid is high and dma_ready is low, dma_valid, dma_addr and dma_data hold their values.
- R11: The command completes with code 0 when the eighth beat is accepted. If dma_err is returned with an accepted beat, the packet stops at that beat and the command completes with esr bit 11 and code 0.
- R12: While a packet is in flight, xs_start, fe_req and cmpl_req are ignored. When fe_req and cmpl_req arrive together with no packet in flight, the word-count overflow outcome takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | A new command begins |
| cmd_rw | input | 1 | The new command is a sector read/write (clears errors) |
| cmpl_req | input | 1 | Completion request from the sequencer |
| cmpl_flags | input | 12 | Error-status flags to merge |
| cmpl_code | input | 8 | New error code |
| fe_req | input | 1 | Check the fill/empty word count |
| fe_go | output | 1 | Word count accepted, transfer may proceed |
| xs_start | input | 1 | Start the extended status packet |
| xs_addr | input | 18 | Packet byte address |
| drv_sel | input | 1 | Selected drive |
| den_sel | input | 1 | Requested density (1 = double) |
| ie | input | 1 | Interrupt enable |
| media | input | 2 | Per-drive media present |
| dd | input | 2 | Per-drive double-density media |
| wcount | input | 8 | Word count |
| trk0 | input | 8 | Drive 0 head track |
| trk1 | input | 8 | Drive 1 head track |
| req_trk | input | 8 | Requested track |
| req_sec | input | 8 | Requested sector |
| dma_valid | output | 1 | Byte beat valid |
| dma_ready | input | 1 | Beat accepted |
| dma_err | input | 1 | Accepted beat hit nonexistent memory |
| dma_addr | output | 18 | Beat byte address |
| dma_data | output | 8 | Beat byte |
| done | output | 1 | Command done |
| irq | output | 1 | Interrupt request |
| csr_err | output | 1 | Control error bit |
| esr | output | 12 | Error-status register |
| dbr | output | 16 | Data buffer register |
| ecode | output | 8 | Last error code |
| xs_busy | output | 1 | Packet in flight |

## Verification
Two sources of completion can coincide. In the first, the sequencer raises cmpl_req in the same cycle that the eighth packet beat is accepted. The bench holds cmpl_req high, with a nonzero code and the deleted-data flag, in that cycle. It then checks that only the packet's completion took effect: ecode is 0 and bit 6 stays clear. In the second, fe_req with an oversized count and cmpl_req are raised together, and the bench checks that the overflow code 8'h98 wins. In the packet test the bench also pulses xs_start during a beat and checks that the addresses are not disturbed and that no second packet follows.

// File: rtl/cstat_pkg.sv
package cstat_pkg;
    localparam int ESR_W  = 12;
    localparam int ADDR_W = 18;
    localparam int BYTE_W = 8;
    localparam int PKT_N  = 8;
    localparam int IDX_W  = $clog2(PKT_N);

    localparam int B_CRC  = 0;
    localparam int B_INIT = 2;
    localparam int B_PWR  = 3;
    localparam int B_DENE = 4;
    localparam int B_DDEN = 5;
    localparam int B_DEL  = 6;
    localparam int B_RDY  = 7;
    localparam int B_USEL = 8;
    localparam int B_WCO  = 10;
    localparam int B_NXM  = 11;

    localparam logic [ESR_W-1:0] ERR_MASK =
        (ESR_W'(1) << B_NXM) | (ESR_W'(1) << B_WCO) | (ESR_W'(1) << B_DENE) |
        (ESR_W'(1) << B_PWR) | (ESR_W'(1) << B_CRC);
    localparam logic [ESR_W-1:0] DRV_MASK =
        (ESR_W'(1) << B_USEL) | (ESR_W'(1) << B_RDY) | (ESR_W'(1) << B_DDEN);
    localparam logic [BYTE_W-1:0] CODE_WCO = 8'o230;

    localparam int SEC_SD = 128;
    localparam int SEC_DD = 256;

    typedef struct packed {
        logic [ESR_W-1:0]  flags;
        logic [BYTE_W-1:0] code;
    } cmpl_t;

    typedef struct packed {
        logic       drv;
        logic [1:0] media;
        logic [1:0] dd;
    } drv_ctx_t;

    typedef logic [PKT_N-1:0][BYTE_W-1:0] pkt_t;

    function automatic logic [ESR_W-1:0] esr_rebuild(logic [ESR_W-1:0] cur,
                                                    logic [ESR_W-1:0] add,
                                                    drv_ctx_t c);
        logic [ESR_W-1:0] e;
        e = (cur | add) & ~DRV_MASK;
        e[B_USEL] = c.drv;
        e[B_RDY]  = c.media[c.drv];
        e[B_DDEN] = c.media[c.drv] & c.dd[c.drv];
        return e;
    endfunction
endpackage

// File: rtl/cstat_wc_check.sv
module cstat_wc_check
    import cstat_pkg::*;
(
    input  logic              den,
    input  logic [BYTE_W-1:0] wc,
    output logic              ovf
);
    localparam int BW = BYTE_W + 2;
    logic [BW-1:0] bytes;
    logic [BW-1:0] limit;

    always_comb begin
        bytes = BW'({wc, 1'b0});
        limit = den ? BW'(SEC_DD) : BW'(SEC_SD);
        ovf   = bytes > limit;
    end
endmodule

// File: rtl/cstat_xs_stream.sv
module cstat_xs_stream
    import cstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    input  pkt_t              pkt,
    output logic              busy,
    output logic              dma_valid,
    output logic [ADDR_W-1:0] dma_addr,
    output logic [BYTE_W-1:0] dma_data,
    input  logic              dma_ready,
    input  logic              dma_err,
    output logic              fin,
    output logic              fin_nxm
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(PKT_N - 1);

    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] base_q;
    pkt_t              pkt_q;
    logic              accept;

    assign accept    = busy & dma_ready;
    assign fin       = accept & (dma_err | (idx_q == LAST));
    assign fin_nxm   = accept & dma_err;
    assign dma_valid = busy;
    assign dma_addr  = base_q + ADDR_W'(idx_q);
    assign dma_data  = pkt_q[idx_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            idx_q  <= '0;
            base_q <= '0;
            pkt_q  <= '0;
        end else if (!busy && start) begin
            busy   <= 1'b1;
            idx_q  <= '0;
            base_q <= base;
            pkt_q  <= pkt;
        end else if (accept) begin
            if (fin) busy  <= 1'b0;
            else     idx_q <= idx_q + 1'b1;
        end
    end
endmodule

// File: rtl/cstat_status_reg.sv
module cstat_status_reg
    import cstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              evt,
    input  cmpl_t             info,
    input  drv_ctx_t          ctx,
    input  logic              cmd_start,
    input  logic              cmd_rw,
    output logic              done,
    output logic              err,
    output logic [ESR_W-1:0]  esr,
    output logic [15:0]       dbr,
    output logic [BYTE_W-1:0] ecode
);
    logic [ESR_W-1:0] esr_n;

    always_comb esr_n = esr_rebuild(esr, info.flags, ctx);

    always_ff @(posedge clk) begin
        if (rst) begin
            done  <= 1'b0;
            err   <= 1'b0;
            esr   <= '0;
            dbr   <= '0;
            ecode <= '0;
        end else if (evt) begin
            done  <= 1'b1;
            esr   <= esr_n;
            err   <= err | (info.code != '0) | (|(esr_n & ERR_MASK));
            ecode <= info.code;
            dbr   <= 16'(esr_n);
        end else if (cmd_start) begin
            done <= 1'b0;
            err  <= 1'b0;
            if (cmd_rw) begin
                esr   <= esr & (ESR_W'(1) << B_INIT);
                ecode <= '0;
            end
        end
    end
endmodule

// File: rtl/cstat_unit.sv
module cstat_unit
    import cstat_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_start,
    input  logic        cmd_rw,
    input  logic        cmpl_req,
    input  logic [11:0] cmpl_flags,
    input  logic [7:0]  cmpl_code,
    input  logic        fe_req,
    output logic        fe_go,
    input  logic        xs_start,
    input  logic [17:0] xs_addr,
    input  logic        drv_sel,
    input  logic        den_sel,
    input  logic        ie,
    input  logic [1:0]  media,
    input  logic [1:0]  dd,
    input  logic [7:0]  wcount,
    input  logic [7:0]  trk0,
    input  logic [7:0]  trk1,
    input  logic [7:0]  req_trk,
    input  logic [7:0]  req_sec,
    output logic        dma_valid,
    input  logic        dma_ready,
    input  logic        dma_err,
    output logic [17:0] dma_addr,
    output logic [7:0]  dma_data,
    output logic        done,
    output logic        irq,
    output logic        csr_err,
    output logic [11:0] esr,
    output logic [15:0] dbr,
    output logic [7:0]  ecode,
    output logic        xs_busy
);
    logic     wc_ovf, xs_fin, xs_nxm, fe_live, fe_ovf_ev, evt;
    cmpl_t    info;
    drv_ctx_t ctx;
    pkt_t     pkt;

    cstat_wc_check u_wc (.den(den_sel), .wc(wcount), .ovf(wc_ovf));

    always_comb begin
        pkt[0] = ecode;
        pkt[1] = wcount;
        pkt[2] = trk0;
        pkt[3] = trk1;
        pkt[4] = req_trk;
        pkt[5] = req_sec;
        pkt[6] = {drv_sel, dd[1], media[drv_sel], dd[0], 3'b000, den_sel};
        pkt[7] = drv_sel ? trk1 : trk0;
    end

    cstat_xs_stream u_xs (
        .clk(clk), .rst(rst), .start(xs_start), .base(xs_addr), .pkt(pkt),
        .busy(xs_busy), .dma_valid(dma_valid), .dma_addr(dma_addr),
        .dma_data(dma_data), .dma_ready(dma_ready), .dma_err(dma_err),
        .fin(xs_fin), .fin_nxm(xs_nxm)
    );

    // Requests other than the packet's own end are only honoured when idle.
    assign fe_live   = fe_req & ~xs_busy;
    assign fe_ovf_ev = fe_live & wc_ovf;
    assign evt       = xs_fin | fe_ovf_ev | (cmpl_req & ~xs_busy);

    always_comb begin
        if (xs_fin) begin
            info.flags = xs_nxm ? (ESR_W'(1) << B_NXM) : '0;
            info.code  = '0;
        end else if (fe_ovf_ev) begin
            info.flags = ESR_W'(1) << B_WCO;
            info.code  = CODE_WCO;
        end else begin
            info.flags = cmpl_flags;
            info.code  = cmpl_code;
        end
        ctx.drv   = drv_sel;
        ctx.media = media;
        ctx.dd    = dd;
    end

    cstat_status_reg u_st (
        .clk(clk), .rst(rst), .evt(evt), .info(info), .ctx(ctx),
        .cmd_start(cmd_start), .cmd_rw(cmd_rw), .done(done), .err(csr_err),
        .esr(esr), .dbr(dbr), .ecode(ecode)
    );

    always_ff @(posedge clk) begin
        if (rst) fe_go <= 1'b0;
        else     fe_go <= fe_live & ~wc_ovf;
    end

    assign irq = done & ie;
endmodule

// File: rtl/cstat_unit_chk.sv
module cstat_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        drv_sel,
    input logic        ie,
    input logic        done,
    input logic        irq,
    input logic        csr_err,
    input logic [11:0] esr,
    input logic [15:0] dbr,
    input logic [7:0]  ecode,
    input logic        dma_valid,
    input logic        dma_ready,
    input logic [17:0] dma_addr,
    input logic [7:0]  dma_data
);
    // R3: unit-selected bit follows the drive selected at completion
    a_r3_usel_rebuilt: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> esr[8] == $past(drv_sel));

    // R4: a nonzero code always leaves the error bit set
    a_r4_code_sets_err: assert property (@(posedge clk) disable iff (rst)
        (done && ecode != 8'd0) |-> csr_err);

    // R5: the data buffer mirrors the status word after completion
    a_r5_dbr_mirror: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> dbr == {4'b0000, esr});

    // R6: no interrupt without done and enable
    a_r6_irq_gated: assert property (@(posedge clk) disable iff (rst)
        irq |-> (done && ie));

    // R10: a stalled beat holds still
    a_r10_beat_held: assert property (@(posedge clk) disable iff (rst)
        (dma_valid && !dma_ready) |=> (dma_valid && $stable(dma_addr) && $stable(dma_data)));
endmodule

bind cstat_unit cstat_unit_chk u_chk (
    .clk(clk), .rst(rst), .drv_sel(drv_sel), .ie(ie), .done(done), .irq(irq),
    .csr_err(csr_err), .esr(esr), .dbr(dbr), .ecode(ecode),
    .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_addr(dma_addr),
    .dma_data(dma_data)
);

// File: tb/cstat_unit_test.sv
module cstat_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_start = 0, cmd_rw = 0, cmpl_req = 0, fe_req = 0, xs_start = 0;
    logic [11:0] cmpl_flags = '0;
    logic [7:0]  cmpl_code = '0;
    logic        fe_go;
    logic [17:0] xs_addr = '0;
    logic        drv_sel = 0, den_sel = 0, ie = 0;
    logic [1:0]  media = 2'b11, dd = 2'b01;
    logic [7:0]  wcount = 8'd10, trk0 = 8'd3, trk1 = 8'd44, req_trk = 8'd17, req_sec = 8'd9;
    logic        dma_valid, dma_ready = 0, dma_err = 0;
    logic [17:0] dma_addr;
    logic [7:0]  dma_data;
    logic        done, irq, csr_err, xs_busy;
    logic [11:0] esr;
    logic [15:0] dbr;
    logic [7:0]  ecode;

    int checks = 0;
    int errors = 0;
    logic [11:0] m_esr = '0;
    logic [7:0]  m_code = '0;
    logic        m_err = 0;
    bit          finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cstat_unit uut (.*);

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] model_merge(logic [11:0] add);
        logic [11:0] e;
        e = (m_esr | add) & ~12'h1A0;
        e[8] = drv_sel;
        e[7] = media[drv_sel];
        e[5] = media[drv_sel] & dd[drv_sel];
        return e;
    endfunction

    task automatic model_done(input logic [11:0] add, input logic [7:0] code);
        m_esr  = model_merge(add);
        m_err  = m_err | (code != 0) | (|(m_esr & 12'hC19));
        m_code = code;
    endtask

    task automatic check_status(input string tag);
        chk(done, 1, {tag, " done"});
        chk(esr, m_esr, {tag, " esr"});
        chk(ecode, m_code, {tag, " ecode"});
        chk(csr_err, m_err, {tag, " csr_err"});
        chk(dbr, {4'b0, m_esr}, {tag, " dbr (R5)"});
    endtask

    task automatic complete(input logic [11:0] f, input logic [7:0] c, input string tag);
        cmpl_req = 1; cmpl_flags = f; cmpl_code = c;
        model_done(f, c);
        @(negedge clk);
        cmpl_req = 0; cmpl_flags = 0; cmpl_code = 0;
        check_status(tag);
    endtask

    task automatic start_cmd(input logic rw);
        cmd_start = 1; cmd_rw = rw;
        @(negedge clk);
        cmd_start = 0; cmd_rw = 0;
        m_err = 0;
        if (rw) begin m_esr = m_esr & 12'h004; m_code = 0; end
    endtask

    task automatic t_reset;
        chk(done, 0, "R1 done");
        chk(csr_err, 0, "R1 csr_err");
        chk(irq, 0, "R1 irq");
        chk(dma_valid, 0, "R1 dma_valid");
        chk(xs_busy, 0, "R1 xs_busy");
        chk(fe_go, 0, "R1 fe_go");
        chk({esr, dbr, ecode}, 0, "R1 esr/dbr/ecode");
    endtask

    task automatic t_basic;
        // init done alone: no error (R4); drive 0 ready, double density (R3)
        complete(12'h004, 8'd0, "R2 basic");
        chk(esr, 12'h0A4, "R3 drive0 bits");
        start_cmd(0);
        chk(done, 0, "R7 done cleared");
        chk(esr, 12'h0A4, "R7 esr kept without rw");
        drv_sel = 1; media = 2'b01;
        complete(12'h001, 8'd0, "R4 crc error");
        chk(esr, 12'h105, "R3 drive1 rebuild");
        chk(csr_err, 1, "R4 crc sets err");
        start_cmd(1);
        chk({csr_err, done}, 0, "R7 rw clear flags");
        chk(esr, 12'h004, "R7 rw keeps init done");
        chk(ecode, 0, "R7 rw clears code");
        drv_sel = 0; media = 2'b11;
        complete(12'h040, 8'h21, "R4 code error");
        chk(csr_err, 1, "R4 code sets err");
    endtask

    task automatic t_irq;
        ie = 1; @(negedge clk);
        chk(irq, 1, "R6 irq with done and ie");
        ie = 0; @(negedge clk);
        chk(irq, 0, "R6 irq dropped by ie");
        ie = 1; start_cmd(0);
        chk(irq, 0, "R6 irq dropped by start");
        ie = 0;
    endtask

    task automatic fe_try(input logic den, input logic [7:0] wc, input logic over, input string tag);
        den_sel = den; wcount = wc; fe_req = 1;
        if (over) model_done(12'h400, 8'h98);
        @(negedge clk);
        fe_req = 0;
        chk(fe_go, !over, {tag, " fe_go"});
        if (over) check_status(tag);
        else chk(done, 0, {tag, " no completion"});
        @(negedge clk);
        chk(fe_go, 0, {tag, " fe_go single pulse"});
        start_cmd(1);
    endtask

    task automatic t_fill;
        fe_try(0, 8'd64, 0, "R8 sd limit");
        fe_try(0, 8'd65, 1, "R8 sd over");
        fe_try(1, 8'd128, 0, "R8 dd limit");
        fe_try(1, 8'd129, 1, "R8 dd over");
        // R12: overflow beats a simultaneous completion request
        den_sel = 0; wcount = 8'd200; fe_req = 1; cmpl_req = 1; cmpl_code = 8'h11;
        model_done(12'h400, 8'h98);
        @(negedge clk);
        fe_req = 0; cmpl_req = 0; cmpl_code = 0;
        check_status("R12 fe wins");
        start_cmd(1);
        wcount = 8'd10;
    endtask

    // Sends a packet; err_beat < 8 returns an error on that beat; overlap raises
    // cmpl_req on the final beat and xs_start mid-packet.
    task automatic run_packet(input logic [17:0] a, input int err_beat, input bit overlap, input string tag);
        logic [7:0] exp_b [8];
        int last;
        exp_b[0] = m_code; exp_b[1] = wcount; exp_b[2] = trk0; exp_b[3] = trk1;
        exp_b[4] = req_trk; exp_b[5] = req_sec;
        exp_b[6] = {drv_sel, dd[1], media[drv_sel], dd[0], 3'b000, den_sel};
        exp_b[7] = drv_sel ? trk1 : trk0;
        last = (err_beat < 8) ? err_beat : 7;
        xs_addr = a; xs_start = 1;
        @(negedge clk);
        xs_start = 0;
        for (int i = 0; i <= last; i++) begin
            chk(dma_valid, 1, {tag, " R9 valid"});
            chk(dma_addr, a + 18'(i), {tag, " R9 addr"});
            chk(dma_data, exp_b[i], {tag, " R9 byte"});
            if (i == 2) begin
                dma_ready = 0;
                if (overlap) begin xs_start = 1; xs_addr = 18'h00100; end
                @(negedge clk);
                xs_start = 0;
                chk({dma_valid, dma_addr, dma_data}, {1'b1, a + 18'(i), exp_b[i]}, {tag, " R10 stall hold"});
            end
            chk(done, 0, {tag, " R11 not done early"});
            dma_ready = 1;
            dma_err = (i == err_beat);
            if (overlap && i == last) begin cmpl_req = 1; cmpl_code = 8'h33; cmpl_flags = 12'h040; end
            @(negedge clk);
            dma_ready = 0; dma_err = 0; cmpl_req = 0; cmpl_code = 0; cmpl_flags = 0;
        end
        model_done((err_beat < 8) ? 12'h800 : 12'h000, 8'd0);
        check_status({tag, " R11 completion"});
        chk(dma_valid, 0, {tag, " R11 port idle"});
        if (overlap) chk(esr[6], 0, "R12 cmpl_req ignored in flight");
        @(negedge clk);
        chk(dma_valid, 0, {tag, " R12 no restart"});
        start_cmd(1);
    endtask

    task automatic t_packet;
        drv_sel = 1; media = 2'b10; dd = 2'b10; den_sel = 1;
        complete(12'h000, 8'h5A, "R2 preset code");
        start_cmd(0);
        run_packet(18'h3FFF0, 8, 0, "pkt1");
        drv_sel = 0; media = 2'b01; dd = 2'b01; den_sel = 0;
        run_packet(18'h00200, 3, 0, "pkt_err");
        chk(esr[11], 0, "R7 nxm cleared by rw");
        run_packet(18'h01000, 8, 1, "pkt_ovl");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset;
        t_basic;
        t_irq;
        t_fill;
        t_packet;
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule